// File: doc/BRIEF.md
# Halt-Gated Global Cycle Counter

This block keeps a 64-bit cycle count that several processor cores share as a common time base. It counts up by one on every clock. A debugger can stop the count, so that the time base does not jump forward while the cores are held. Each core drives a halted indication. A programmable core-select mask chooses which of those indications matter. When the mask is nonzero and every selected core is halted, the count freezes. It resumes as soon as any selected core runs again. An empty mask, which is the state after reset, means the count never stops.

Software reaches the block through three registers on a small auxiliary bus: a command word, a write-data word and a readback word. Writing the command word starts an operation named by the opcode in its low byte:
- read the low half of the count;
- read the high half of the count;
- load the select mask from the write-data word;
- read the select mask.

Reading the low half also captures the high half of the same count value. The next high-half read is therefore consistent with the low half, even if the count carried between the two commands.

Top module: `halt_gated_counter`

## Requirements
- R1: The command register sits at address BASE (default 0x600), the write-data register at BASE+1 and the readback register at BASE+2. A write to BASE stores the command word and issues it. A write to BASE+1 stores the data word. A read of any of the three addresses returns the current content of that register, and a read of any other address returns zero.
- R2: After reset the count is zero, the select mask is zero and the readback register is zero.
- R3: On each clock where counting is enabled the count increments by exactly one. Otherwise it holds its value.
- R4: Opcode 0x42 (command bits [7:0]) loads the readback register with count bits [31:0], as the count stood at the clock edge that accepted the command. At the same edge it copies count bits [63:32] into a shadow register.
- R5: Opcode 0x43 loads the readback register with the shadow value captured by the most recent 0x42 command. The shadow is zero if no 0x42 command has been issued since reset.
- R6: Opcode 0x47 loads the select mask from bits [3:0] of the write-data register. Bit i of the mask selects core i.
- R7: Opcode 0x48 loads the readback register with the select mask, zero-extended to 32 bits.
- R8: While the select mask is zero, counting is enabled whatever the halt inputs are.
- R9: While the select mask is nonzero, counting stops only when every selected core has its halt input high. Halt inputs of unselected cores have no effect.
- R10: A command with any other opcode changes neither the readback register, nor the select mask, nor the count sequence. Command bits [31:8] do not affect any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_wr | input | 1 | Write strobe for the auxiliary register bus |
| aux_addr | input | 12 | Register address, used for both reads and writes |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data of the addressed register (combinational) |
| core_halted | input | 4 | Per-core halted indication, synchronous, active high |

## Verification
The assertions assume that the halt inputs and bus signals are synchronous to `clk` and settle before each rising edge. They also assume that a write is a single-cycle pulse of `aux_wr` carrying a stable address and data. The bench meets these assumptions by changing every input only on the falling clock edge and by holding `aux_wr` for exactly one cycle per write. It also sets new halt patterns between commands, so each command sees a steady halt state. The random stimulus keeps the write-data word to a 4-bit mask range only when it matters for the check. The random opcodes are drawn from the four defined commands and from a spread of undefined values.

// File: rtl/gfrc_pkg.sv
package gfrc_pkg;

    typedef enum logic [7:0] {
        OP_READ_LO  = 8'h42,
        OP_READ_HI  = 8'h43,
        OP_SET_SEL  = 8'h47,
        OP_READ_SEL = 8'h48
    } gfrc_op_e;

    // One-hot command strobes produced by the opcode decoder
    typedef struct packed {
        logic read_lo;
        logic read_hi;
        logic set_sel;
        logic read_sel;
    } gfrc_cmd_t;

    // Which register slot an address selects
    typedef struct packed {
        logic cmd;
        logic wdata;
        logic rback;
    } gfrc_slot_t;

    function automatic gfrc_cmd_t decode_opcode(input logic [7:0] opc);
        gfrc_cmd_t c;
        c = '0;
        case (opc)
            OP_READ_LO:  c.read_lo  = 1'b1;
            OP_READ_HI:  c.read_hi  = 1'b1;
            OP_SET_SEL:  c.set_sel  = 1'b1;
            OP_READ_SEL: c.read_sel = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gfrc_aux_decode.sv
module gfrc_aux_decode
    import gfrc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 12'h600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aux_wr,
    input  logic [ADDR_W-1:0] aux_addr,
    input  logic [DATA_W-1:0] aux_wdata,
    output gfrc_slot_t        slot,
    output gfrc_cmd_t         cmd_pulse,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] wdata_q
);

    localparam logic [ADDR_W-1:0] ADDR_CMD   = BASE;
    localparam logic [ADDR_W-1:0] ADDR_WDATA = ADDR_W'(BASE + 1);
    localparam logic [ADDR_W-1:0] ADDR_RBACK = ADDR_W'(BASE + 2);

    always_comb begin
        slot.cmd   = (aux_addr == ADDR_CMD);
        slot.wdata = (aux_addr == ADDR_WDATA);
        slot.rback = (aux_addr == ADDR_RBACK);
    end

    // Only the low byte selects the operation; upper bits are carried but unused
    always_comb begin
        if (aux_wr && slot.cmd)
            cmd_pulse = decode_opcode(aux_wdata[7:0]);
        else
            cmd_pulse = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            wdata_q <= '0;
        end else if (aux_wr) begin
            if (slot.cmd)   cmd_q   <= aux_wdata;
            if (slot.wdata) wdata_q <= aux_wdata;
        end
    end

endmodule

// File: rtl/gfrc_halt_gate.sv
module gfrc_halt_gate #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_sel,
    input  logic [NUM_CORES-1:0] sel_in,
    input  logic [NUM_CORES-1:0] core_halted,
    output logic [NUM_CORES-1:0] sel_q,
    output logic                 run
);

    logic [NUM_CORES-1:0] core_active;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (load_sel)
            sel_q <= sel_in;
    end

    // A selected core that is not halted keeps the count alive
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        assign core_active[i] = sel_q[i] & ~core_halted[i];
    end

    assign run = (sel_q == '0) | (|core_active);

endmodule

// File: rtl/gfrc_count.sv
module gfrc_count #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               snap,
    output logic [CNT_W-1:0]   count_q,
    output logic [CNT_W/2-1:0] shadow_q
);

    localparam int HALF_W = CNT_W / 2;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (run)
            count_q <= count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (snap)
            shadow_q <= count_q[CNT_W-1:HALF_W];
    end

endmodule

// File: rtl/halt_gated_counter.sv
module halt_gated_counter
    import gfrc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 64,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h600
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 aux_wr,
    input  logic [ADDR_W-1:0]    aux_addr,
    input  logic [CNT_W/2-1:0]   aux_wdata,
    output logic [CNT_W/2-1:0]   aux_rdata,
    input  logic [NUM_CORES-1:0] core_halted
);

    localparam int DATA_W = CNT_W / 2;

    gfrc_slot_t           slot;
    gfrc_cmd_t            cmd_pulse;
    logic [DATA_W-1:0]    cmd_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [NUM_CORES-1:0] sel_q;
    logic                 run;
    logic [CNT_W-1:0]     count_q;
    logic [DATA_W-1:0]    shadow_q;
    logic [DATA_W-1:0]    rback_q;

    gfrc_aux_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .aux_wr    (aux_wr),
        .aux_addr  (aux_addr),
        .aux_wdata (aux_wdata),
        .slot      (slot),
        .cmd_pulse (cmd_pulse),
        .cmd_q     (cmd_q),
        .wdata_q   (wdata_q)
    );

    gfrc_halt_gate #(.NUM_CORES(NUM_CORES)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .load_sel    (cmd_pulse.set_sel),
        .sel_in      (wdata_q[NUM_CORES-1:0]),
        .core_halted (core_halted),
        .sel_q       (sel_q),
        .run         (run)
    );

    gfrc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .snap     (cmd_pulse.read_lo),
        .count_q  (count_q),
        .shadow_q (shadow_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rback_q <= '0;
        else if (cmd_pulse.read_lo)
            rback_q <= count_q[DATA_W-1:0];
        else if (cmd_pulse.read_hi)
            rback_q <= shadow_q;
        else if (cmd_pulse.read_sel)
            rback_q <= DATA_W'(sel_q);
    end

    always_comb begin
        if (slot.cmd)        aux_rdata = cmd_q;
        else if (slot.wdata) aux_rdata = wdata_q;
        else if (slot.rback) aux_rdata = rback_q;
        else                 aux_rdata = '0;
    end

endmodule

// File: rtl/gfrc_checker.sv
module gfrc_checker
    import gfrc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 64,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h600
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 aux_wr,
    input logic [ADDR_W-1:0]    aux_addr,
    input logic [CNT_W/2-1:0]   aux_wdata,
    input logic [NUM_CORES-1:0] core_halted,
    input logic [CNT_W-1:0]     count_q,
    input logic [NUM_CORES-1:0] sel_q,
    input logic [CNT_W/2-1:0]   rback_q,
    input logic [CNT_W/2-1:0]   shadow_q,
    input logic [CNT_W/2-1:0]   wdata_q
);

    localparam int HALF_W = CNT_W / 2;

    logic cmd_wr;
    logic known_op;
    logic all_sel_halted;

    assign cmd_wr   = aux_wr && (aux_addr == BASE);
    assign known_op = (aux_wdata[7:0] == OP_READ_LO)  || (aux_wdata[7:0] == OP_READ_HI) ||
                      (aux_wdata[7:0] == OP_SET_SEL)  || (aux_wdata[7:0] == OP_READ_SEL);
    assign all_sel_halted = ((sel_q & ~core_halted) == '0);

    assert_reset_clears_R2: assert property (@(posedge clk)
        rst |=> (count_q == '0) && (sel_q == '0) && (rback_q == '0));

    assert_empty_mask_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_q == '0) |=> (count_q == $past(count_q) + CNT_W'(1)));

    assert_frozen_when_halted_R9: assert property (@(posedge clk) disable iff (rst)
        ((sel_q != '0) && all_sel_halted) |=> $stable(count_q));

    assert_step_of_one_R3: assert property (@(posedge clk) disable iff (rst)
        !all_sel_halted |=> (count_q == $past(count_q) + CNT_W'(1)));

    assert_low_snap_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && aux_wdata[7:0] == OP_READ_LO) |=>
            (rback_q == $past(count_q[HALF_W-1:0])) &&
            (shadow_q == $past(count_q[CNT_W-1:HALF_W])));

    assert_high_from_shadow_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && aux_wdata[7:0] == OP_READ_HI) |=> (rback_q == $past(shadow_q)));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && aux_wdata[7:0] == OP_SET_SEL) |=> (sel_q == $past(wdata_q[NUM_CORES-1:0])));

    assert_mask_read_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && aux_wdata[7:0] == OP_READ_SEL) |=> (rback_q == HALF_W'($past(sel_q))));

    assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !known_op) |=> $stable(rback_q) && $stable(sel_q));

endmodule

bind halt_gated_counter gfrc_checker #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .BASE      (BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .aux_wr      (aux_wr),
    .aux_addr    (aux_addr),
    .aux_wdata   (aux_wdata),
    .core_halted (core_halted),
    .count_q     (count_q),
    .sel_q       (sel_q),
    .rback_q     (rback_q),
    .shadow_q    (shadow_q),
    .wdata_q     (wdata_q)
);

// File: tb/halt_gated_counter_test.sv
`timescale 1ns/1ps
module halt_gated_counter_test;

    localparam logic [11:0] A_CMD = 12'h600;
    localparam logic [11:0] A_WD  = 12'h601;
    localparam logic [11:0] A_RB  = 12'h602;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        aux_wr = 1'b0;
    logic [11:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic [31:0] aux_rdata;
    logic [3:0]  core_halted = '0;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    halt_gated_counter uut (
        .clk         (clk),
        .rst         (rst),
        .aux_wr      (aux_wr),
        .aux_addr    (aux_addr),
        .aux_wdata   (aux_wdata),
        .aux_rdata   (aux_rdata),
        .core_halted (core_halted)
    );

    // Reference model built from the requirements
    logic [63:0] m_cnt;
    logic [3:0]  m_sel;
    logic [31:0] m_wd, m_rb, m_sh, m_cmd;

    function automatic bit f_run(input logic [3:0] sel, input logic [3:0] h);
        return (sel == 4'h0) || ((sel & ~h) != 4'h0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_sel <= '0; m_wd <= '0; m_rb <= '0; m_sh <= '0; m_cmd <= '0;
        end else begin
            if (aux_wr && aux_addr == A_WD) m_wd <= aux_wdata;
            if (aux_wr && aux_addr == A_CMD) begin
                m_cmd <= aux_wdata;
                case (aux_wdata[7:0])
                    8'h42: begin m_rb <= m_cnt[31:0]; m_sh <= m_cnt[63:32]; end
                    8'h43: m_rb <= m_sh;
                    8'h47: m_sel <= m_wd[3:0];
                    8'h48: m_rb <= {28'h0, m_sel};
                    default: ;
                endcase
            end
            if (f_run(m_sel, core_halted)) m_cnt <= m_cnt + 64'd1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic aux_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        aux_wr = 1'b1; aux_addr = a; aux_wdata = d;
        @(negedge clk);
        aux_wr = 1'b0;
    endtask

    task automatic aux_read(input logic [11:0] a, output logic [31:0] d);
        aux_addr = a;
        #1;
        d = aux_rdata;
    endtask

    task automatic issue(input logic [7:0] op);
        aux_write(A_CMD, {8'h00, 16'($urandom), op});
    endtask

    task automatic read_low(output logic [31:0] d);
        issue(8'h42);
        aux_read(A_RB, d);
    endtask

    task automatic set_mask(input logic [3:0] m);
        aux_write(A_WD, {28'h0, m});
        issue(8'h47);
    endtask

    logic [31:0] r, l1, l2;

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        aux_read(A_RB, r);  check("R2 readback", r, 32'h0);
        issue(8'h48); aux_read(A_RB, r); check("R2 mask", r, 32'h0);
        issue(8'h43); aux_read(A_RB, r); check("R5 shadow after reset", r, 32'h0);

        // R8: empty mask, all cores halted, count advances
        core_halted = 4'hF;
        read_low(l1); check("R4 low", l1, m_rb);
        repeat (4) @(negedge clk);
        read_low(l2); check("R4 low", l2, m_rb);
        check("R8 advances", 32'(l2 != l1), 32'h1);

        // R6/R9: selected cores all halted -> frozen
        set_mask(4'h5);
        issue(8'h48); aux_read(A_RB, r); check("R6 mask load", r, 32'h5);
        core_halted = 4'h5;
        read_low(l1);
        repeat (6) @(negedge clk);
        read_low(l2); check("R9 frozen", l2, l1);
        check("R3 model", l2, m_rb);

        // R9: one selected core running -> counts
        core_halted = 4'h4;
        read_low(l1);
        repeat (3) @(negedge clk);
        read_low(l2); check("R9 resumes", 32'(l2 != l1), 32'h1);
        check("R3 model", l2, m_rb);

        // R9: unselected halts ignored
        set_mask(4'h1);
        core_halted = 4'hE;
        read_low(l1);
        repeat (3) @(negedge clk);
        read_low(l2); check("R9 unselected ignored", 32'(l2 != l1), 32'h1);

        // R1: register read-back
        aux_write(A_WD, 32'hA5C3_0F1E);
        aux_read(A_WD, r);  check("R1 wdata", r, 32'hA5C3_0F1E);
        aux_write(A_CMD, 32'h00BE_EF99);
        aux_read(A_CMD, r); check("R1 cmd", r, 32'h00BE_EF99);
        aux_read(12'h603, r); check("R1 other addr", r, 32'h0);

        // R10: unknown opcode leaves readback and mask alone
        issue(8'h48); aux_read(A_RB, l1);
        aux_write(A_WD, 32'h0000_000F);
        issue(8'h46);
        aux_read(A_RB, r); check("R10 readback kept", r, l1);
        issue(8'h48); aux_read(A_RB, r); check("R10 mask kept", r, 32'h1);
        // R10: upper command bits do not matter
        aux_write(A_CMD, 32'hFFFF_FF48);
        aux_read(A_RB, r); check("R10 upper bits", r, 32'h1);

        // Random phase
        for (int i = 0; i < 400; i++) begin
            int pick;
            core_halted = 4'($urandom);
            pick = int'($urandom_range(0, 5));
            case (pick)
                0: begin set_mask(4'($urandom)); issue(8'h48);
                         aux_read(A_RB, r); check("R6/R7 random mask", r, m_rb); end
                1: begin issue(8'h42); aux_read(A_RB, r); check("R4 random low", r, m_rb); end
                2: begin issue(8'h43); aux_read(A_RB, r); check("R5 random high", r, m_rb); end
                3: begin issue(8'h48); aux_read(A_RB, r); check("R7 random mask read", r, m_rb); end
                4: begin
                    logic [7:0] op;
                    op = 8'($urandom);
                    if (op inside {8'h42, 8'h43, 8'h47, 8'h48}) op = 8'h00;
                    issue(op); aux_read(A_RB, r); check("R10 random unknown", r, m_rb);
                end
                default: begin
                    repeat (int'($urandom_range(1, 5))) @(negedge clk);
                    issue(8'h42); aux_read(A_RB, r); check("R3 random gap", r, m_rb);
                end
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule